// File: doc/BRIEF.md
# Multi-port GPIO register controller

This block gives software access to four ports of general-purpose pins through a small synchronous register bus. Ports 0, 1 and 2 are plain bidirectional ports of 8, 24 and 13 pins. Port 3 is a mixed port with three kinds of pins: 6 bidirectional pins, 23 input-only pins and 24 output-only pins. Every output latch and every direction bit is changed only by a write to a set register or to a clear register. Its present value is then read back from a state register. Port 2 also has a small select register, which is passed out to neighbouring pin-multiplexing logic.

Port 3 does not place its pins on register bits in order. Its bidirectional pins are driven through bits 25 and up of the port-3 output registers. Their direction is held in the upper bits of the port-2 direction register. Their input levels appear at scattered bits of the port-3 input word. Every pin input passes through two synchronizing flops before it can be read. Read data is registered, so the word selected by `bus_addr` in one cycle appears on `bus_rdata` after the next rising edge.

Top module: `gpio_quad_ctrl`

## Requirements
- R1: While reset is held, and directly after it is released, every output-enable, every output level, `p2_sel` and `bus_rdata` is 0.
- R2: A write to an output-set or direction-set offset makes each addressed bit whose write-data bit is 1 equal to 1. Bits whose write-data bit is 0 keep their value.
- R3: A write to an output-clear or direction-clear offset makes each addressed bit whose write-data bit is 1 equal to 0. Bits whose write-data bit is 0 keep their value.
- R4: A direction bit of 1 drives the matching `*_pin_oe` bit high (the pin is an output). A direction bit of 0 drives it low (the pin is an input).
- R5: Port 0 is based at 0x40 and port 1 at 0x60. From each base, the offsets are: input level +0x00, output set +0x04, output clear +0x08, output state +0x0C, direction set +0x10, direction clear +0x14, direction state +0x18.
- R6: Port 2 uses these offsets: direction set 0x10, direction clear 0x14, direction state 0x18, input level 0x1C, output set 0x20, output clear 0x24. Bits 0 to 12 of these registers belong to the port-2 pins.
- R7: The port-2 select register has set 0x28, clear 0x2C and state 0x30. It holds 3 bits and drives `p2_sel`.
- R8: Mixed pin n (0 to 5) of port 3 drives the value of bit 25+n of the port-3 output registers. These are set 0x04, clear 0x08 and state 0x0C. Its output-enable is bit 25+n of the port-2 direction registers.
- R9: The input levels of mixed pins 0 to 4 read at bits 10 to 14 of the port-3 input word (offset 0x00). Mixed pin 5 reads at bit 24.
- R10: Output-only pin k (0 to 23) drives bit k of the port-3 output registers. It reads back at bit k of offset 0x0C.
- R11: Input-only pin k reads in the port-3 input word at these bits: bit k for k 0 to 9, bit k+5 for k 10 to 18, and bit k+6 for k 19 to 22.
- R12: A pin level applied before rising edge e is first visible on `bus_rdata` after edge e+2, because of two synchronizing flops and the registered read. `bus_rdata` shows the register addressed in the cycle before.
- R13: An output latch keeps its value while its pin is an input. Setting the direction bit then drives that stored value in the same cycle that the output-enable rises.
- R14: Set, clear and unmapped offsets read 0. Bits 24 and 31 of the port-3 output word read 0. Writes to state, input-level or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the previous cycle's address |
| p0_pin_in | input | 8 | Port 0 pin levels |
| p0_pin_out | output | 8 | Port 0 output latch |
| p0_pin_oe | output | 8 | Port 0 output enables |
| p1_pin_in | input | 24 | Port 1 pin levels |
| p1_pin_out | output | 24 | Port 1 output latch |
| p1_pin_oe | output | 24 | Port 1 output enables |
| p2_pin_in | input | 13 | Port 2 pin levels |
| p2_pin_out | output | 13 | Port 2 output latch |
| p2_pin_oe | output | 13 | Port 2 output enables |
| p2_sel | output | 3 | Port 2 select register |
| mix_pin_in | input | 6 | Port 3 mixed pin levels |
| mix_pin_out | output | 6 | Port 3 mixed pin output latch |
| mix_pin_oe | output | 6 | Port 3 mixed pin output enables |
| ino_pin_in | input | 23 | Port 3 input-only pin levels |
| outo_pin_out | output | 24 | Port 3 output-only pin levels |

## Verification
A single write to the port-2 direction-set offset can change two ports in the same cycle: it can raise port-2 output-enables and port-3 mixed output-enables at once. The bench provokes this with one word that has bits in both ranges. In the cycle after the write, it compares `p2_pin_oe` and `mix_pin_oe` against its model. Pin inputs also keep changing while register reads follow one another back to back. Every cycle the model predicts the exact word that the two synchronizer stages and the registered read should show. A one-cycle slip in either path is therefore reported.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  // port 3 fixed geometry
  localparam int MIX_N        = 6;
  localparam int INO_N        = 23;
  localparam int OUTO_N       = 24;
  localparam int MIX_OUT_BASE = 25;
  localparam int MIX_IN_BASE  = 10;
  localparam int MIX_SPLIT    = 5;
  localparam int MIX_LAST_POS = 24;
  localparam int INO_LOW_END  = 10;
  localparam int INO_MID_END  = 19;

  // port 3 and port 2 offsets
  localparam logic [AW-1:0] A3_LVL  = 8'h00;
  localparam logic [AW-1:0] A3_OSET = 8'h04;
  localparam logic [AW-1:0] A3_OCLR = 8'h08;
  localparam logic [AW-1:0] A3_OVAL = 8'h0C;
  localparam logic [AW-1:0] A2_DSET = 8'h10;
  localparam logic [AW-1:0] A2_DCLR = 8'h14;
  localparam logic [AW-1:0] A2_DVAL = 8'h18;
  localparam logic [AW-1:0] A2_LVL  = 8'h1C;
  localparam logic [AW-1:0] A2_OSET = 8'h20;
  localparam logic [AW-1:0] A2_OCLR = 8'h24;
  localparam logic [AW-1:0] A2_SSET = 8'h28;
  localparam logic [AW-1:0] A2_SCLR = 8'h2C;
  localparam logic [AW-1:0] A2_SVAL = 8'h30;

  // plain ports: base plus relative offset
  localparam logic [AW-1:0] BASE0  = 8'h40;
  localparam logic [AW-1:0] BASE1  = 8'h60;
  localparam logic [AW-1:0] R_LVL  = 8'h00;
  localparam logic [AW-1:0] R_OSET = 8'h04;
  localparam logic [AW-1:0] R_OCLR = 8'h08;
  localparam logic [AW-1:0] R_OVAL = 8'h0C;
  localparam logic [AW-1:0] R_DSET = 8'h10;
  localparam logic [AW-1:0] R_DCLR = 8'h14;
  localparam logic [AW-1:0] R_DVAL = 8'h18;

  function automatic logic [DW-1:0] low_mask(input int w);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < w);
    return m;
  endfunction

  // bit of the port-3 input word carrying mixed pin n
  function automatic int mix_in_pos(input int n);
    return (n < MIX_SPLIT) ? MIX_IN_BASE + n : MIX_LAST_POS;
  endfunction

  // bit of port-3 output / port-2 direction words for mixed pin n
  function automatic int mix_out_pos(input int n);
    return MIX_OUT_BASE + n;
  endfunction

  // bit of the port-3 input word carrying input-only pin k
  function automatic int ino_pos(input int k);
    if (k < INO_LOW_END) return k;
    else if (k < INO_MID_END) return k + 5;
    else return k + 6;
  endfunction

  localparam logic [DW-1:0] P3_OUT_MASK =
    low_mask(OUTO_N) | (low_mask(MIX_N) << MIX_OUT_BASE);
endpackage

// File: rtl/gq_sync2.sv
module gq_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gq_setclr_reg.sv
module gq_setclr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_hit,
  input  logic         clr_hit,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (set_hit) q <= q | wbits;
    else if (clr_hit) q <= q & ~wbits;
  end
endmodule

// File: rtl/gq_std_port.sv
module gq_std_port #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] wbits,
  input  logic         hit_oset,
  input  logic         hit_oclr,
  input  logic         hit_dset,
  input  logic         hit_dclr,
  output logic [N-1:0] lvl,
  output logic [N-1:0] lat,
  output logic [N-1:0] dir
);
  gq_sync2 #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gq_setclr_reg #(.W(N)) u_lat (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_oset), .clr_hit(hit_oclr),
    .wbits(wbits), .q(lat)
  );

  gq_setclr_reg #(.W(N)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_dset), .clr_hit(hit_dclr),
    .wbits(wbits), .q(dir)
  );
endmodule

// File: rtl/gpio_quad_ctrl.sv
module gpio_quad_ctrl
  import gq_pkg::*;
#(
  parameter int P0_N  = 8,
  parameter int P1_N  = 24,
  parameter int P2_N  = 13,
  parameter int SEL_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [P0_N-1:0]   p0_pin_in,
  output logic [P0_N-1:0]   p0_pin_out,
  output logic [P0_N-1:0]   p0_pin_oe,
  input  logic [P1_N-1:0]   p1_pin_in,
  output logic [P1_N-1:0]   p1_pin_out,
  output logic [P1_N-1:0]   p1_pin_oe,
  input  logic [P2_N-1:0]   p2_pin_in,
  output logic [P2_N-1:0]   p2_pin_out,
  output logic [P2_N-1:0]   p2_pin_oe,
  output logic [SEL_N-1:0]  p2_sel,
  input  logic [MIX_N-1:0]  mix_pin_in,
  output logic [MIX_N-1:0]  mix_pin_out,
  output logic [MIX_N-1:0]  mix_pin_oe,
  input  logic [INO_N-1:0]  ino_pin_in,
  output logic [OUTO_N-1:0] outo_pin_out
);
  localparam logic [DW-1:0] P2_DIR_MASK =
    low_mask(P2_N) | (low_mask(MIX_N) << MIX_OUT_BASE);

  // ---------------- write decode (named for the checker) -------------
  logic hit_p0_oset, hit_p0_oclr, hit_p0_dset, hit_p0_dclr;
  logic hit_p1_oset, hit_p1_oclr, hit_p1_dset, hit_p1_dclr;
  logic hit_p2_oset, hit_p2_oclr, hit_p2_dset, hit_p2_dclr;
  logic hit_p2_sset, hit_p2_sclr, hit_p3_oset, hit_p3_oclr;

  assign hit_p0_oset = bus_we && (bus_addr == BASE0 + R_OSET);
  assign hit_p0_oclr = bus_we && (bus_addr == BASE0 + R_OCLR);
  assign hit_p0_dset = bus_we && (bus_addr == BASE0 + R_DSET);
  assign hit_p0_dclr = bus_we && (bus_addr == BASE0 + R_DCLR);
  assign hit_p1_oset = bus_we && (bus_addr == BASE1 + R_OSET);
  assign hit_p1_oclr = bus_we && (bus_addr == BASE1 + R_OCLR);
  assign hit_p1_dset = bus_we && (bus_addr == BASE1 + R_DSET);
  assign hit_p1_dclr = bus_we && (bus_addr == BASE1 + R_DCLR);
  assign hit_p2_oset = bus_we && (bus_addr == A2_OSET);
  assign hit_p2_oclr = bus_we && (bus_addr == A2_OCLR);
  assign hit_p2_dset = bus_we && (bus_addr == A2_DSET);
  assign hit_p2_dclr = bus_we && (bus_addr == A2_DCLR);
  assign hit_p2_sset = bus_we && (bus_addr == A2_SSET);
  assign hit_p2_sclr = bus_we && (bus_addr == A2_SCLR);
  assign hit_p3_oset = bus_we && (bus_addr == A3_OSET);
  assign hit_p3_oclr = bus_we && (bus_addr == A3_OCLR);

  // ---------------- plain ports 0 and 1 --------------------------------
  logic [P0_N-1:0] p0_lvl;
  logic [P1_N-1:0] p1_lvl;

  gq_std_port #(.N(P0_N)) u_port0 (
    .clk(clk), .rst_n(rst_n), .pin_in(p0_pin_in),
    .wbits(bus_wdata[P0_N-1:0]),
    .hit_oset(hit_p0_oset), .hit_oclr(hit_p0_oclr),
    .hit_dset(hit_p0_dset), .hit_dclr(hit_p0_dclr),
    .lvl(p0_lvl), .lat(p0_pin_out), .dir(p0_pin_oe)
  );

  gq_std_port #(.N(P1_N)) u_port1 (
    .clk(clk), .rst_n(rst_n), .pin_in(p1_pin_in),
    .wbits(bus_wdata[P1_N-1:0]),
    .hit_oset(hit_p1_oset), .hit_oclr(hit_p1_oclr),
    .hit_dset(hit_p1_dset), .hit_dclr(hit_p1_dclr),
    .lvl(p1_lvl), .lat(p1_pin_out), .dir(p1_pin_oe)
  );

  // ---------------- port 2 ---------------------------------------------
  logic [P2_N-1:0] p2_lvl;
  logic [DW-1:0]   p2_dir_q;   // also carries port-3 mixed directions

  gq_sync2 #(.W(P2_N)) u_p2_sync (
    .clk(clk), .rst_n(rst_n), .d(p2_pin_in), .q(p2_lvl)
  );

  gq_setclr_reg #(.W(P2_N)) u_p2_lat (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_p2_oset), .clr_hit(hit_p2_oclr),
    .wbits(bus_wdata[P2_N-1:0]), .q(p2_pin_out)
  );

  gq_setclr_reg #(.W(DW)) u_p2_dir (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_p2_dset), .clr_hit(hit_p2_dclr),
    .wbits(bus_wdata & P2_DIR_MASK), .q(p2_dir_q)
  );

  gq_setclr_reg #(.W(SEL_N)) u_p2_sel (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_p2_sset), .clr_hit(hit_p2_sclr),
    .wbits(bus_wdata[SEL_N-1:0]), .q(p2_sel)
  );

  assign p2_pin_oe = p2_dir_q[P2_N-1:0];

  // ---------------- port 3 ---------------------------------------------
  logic [DW-1:0]    p3_out_q;
  logic [MIX_N-1:0] mix_lvl;
  logic [INO_N-1:0] ino_lvl;
  logic [DW-1:0]    p3_lvl_word;

  gq_setclr_reg #(.W(DW)) u_p3_lat (
    .clk(clk), .rst_n(rst_n), .set_hit(hit_p3_oset), .clr_hit(hit_p3_oclr),
    .wbits(bus_wdata & P3_OUT_MASK), .q(p3_out_q)
  );

  gq_sync2 #(.W(MIX_N)) u_mix_sync (
    .clk(clk), .rst_n(rst_n), .d(mix_pin_in), .q(mix_lvl)
  );

  gq_sync2 #(.W(INO_N)) u_ino_sync (
    .clk(clk), .rst_n(rst_n), .d(ino_pin_in), .q(ino_lvl)
  );

  for (genvar g = 0; g < MIX_N; g++) begin : g_mix
    assign mix_pin_out[g] = p3_out_q[mix_out_pos(g)];
    assign mix_pin_oe[g]  = p2_dir_q[mix_out_pos(g)];
  end

  assign outo_pin_out = p3_out_q[OUTO_N-1:0];

  always_comb begin
    p3_lvl_word = '0;
    for (int k = 0; k < INO_N; k++) p3_lvl_word[ino_pos(k)] = ino_lvl[k];
    for (int n = 0; n < MIX_N; n++) p3_lvl_word[mix_in_pos(n)] = mix_lvl[n];
  end

  // ---------------- registered read path -------------------------------
  logic [DW-1:0] rd_next;

  always_comb begin
    unique case (bus_addr)
      A3_LVL:         rd_next = p3_lvl_word;
      A3_OVAL:        rd_next = p3_out_q;
      A2_DVAL:        rd_next = p2_dir_q;
      A2_LVL:         rd_next = DW'(p2_lvl);
      A2_SVAL:        rd_next = DW'(p2_sel);
      BASE0 + R_LVL:  rd_next = DW'(p0_lvl);
      BASE0 + R_OVAL: rd_next = DW'(p0_pin_out);
      BASE0 + R_DVAL: rd_next = DW'(p0_pin_oe);
      BASE1 + R_LVL:  rd_next = DW'(p1_lvl);
      BASE1 + R_OVAL: rd_next = DW'(p1_pin_out);
      BASE1 + R_DVAL: rd_next = DW'(p1_pin_oe);
      default:        rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gq_checker.sv
module gq_checker
  import gq_pkg::*;
#(
  parameter int P0_N  = 8,
  parameter int SEL_N = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [P0_N-1:0]   p0_pin_out,
  input logic [P0_N-1:0]   p0_pin_oe,
  input logic [MIX_N-1:0]  mix_pin_oe,
  input logic [OUTO_N-1:0] outo_pin_out,
  input logic [SEL_N-1:0]  p2_sel,
  input logic              hit_p0_oset,
  input logic              hit_p0_oclr,
  input logic              hit_p0_dset,
  input logic              hit_p0_dclr,
  input logic              hit_p2_dset
);
  p_oset_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_p0_oset |=> p0_pin_out == ($past(p0_pin_out) | $past(bus_wdata[P0_N-1:0])));

  p_oclr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_p0_oclr |=> p0_pin_out == ($past(p0_pin_out) & ~$past(bus_wdata[P0_N-1:0])));

  p_latch_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_p0_dset || hit_p0_dclr) |=> $stable(p0_pin_out));

  p_mix_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_p2_dset |=> ((mix_pin_oe & $past(bus_wdata[MIX_OUT_BASE +: MIX_N]))
                     == $past(bus_wdata[MIX_OUT_BASE +: MIX_N])));

  p_idle_stable_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(p0_pin_out) && $stable(p0_pin_oe) &&
                 $stable(outo_pin_out) && $stable(p2_sel)));

  p_unused_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A3_OVAL) |=> (bus_rdata[24] == 1'b0 && bus_rdata[31] == 1'b0));
endmodule

bind gpio_quad_ctrl gq_checker #(.P0_N(P0_N), .SEL_N(SEL_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .p0_pin_out(p0_pin_out), .p0_pin_oe(p0_pin_oe), .mix_pin_oe(mix_pin_oe),
  .outo_pin_out(outo_pin_out), .p2_sel(p2_sel),
  .hit_p0_oset(hit_p0_oset), .hit_p0_oclr(hit_p0_oclr),
  .hit_p0_dset(hit_p0_dset), .hit_p0_dclr(hit_p0_dclr),
  .hit_p2_dset(hit_p2_dset)
);

// File: tb/sim_gpio_quad_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_quad_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  p0_pin_in = '0;
  logic [7:0]  p0_pin_out, p0_pin_oe;
  logic [23:0] p1_pin_in = '0;
  logic [23:0] p1_pin_out, p1_pin_oe;
  logic [12:0] p2_pin_in = '0;
  logic [12:0] p2_pin_out, p2_pin_oe;
  logic [2:0]  p2_sel;
  logic [5:0]  mix_pin_in = '0;
  logic [5:0]  mix_pin_out, mix_pin_oe;
  logic [22:0] ino_pin_in = '0;
  logic [23:0] outo_pin_out;

  always #4 clk = ~clk;   // 125 MHz

  gpio_quad_ctrl u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state
  logic [31:0] m_p0o, m_p0d, m_p1o, m_p1d, m_p2o, m_p2d, m_p3o, m_sel, m_rd;
  logic [31:0] s1_p0, s2_p0, s1_p1, s2_p1, s1_p2, s2_p2;
  logic [5:0]  s1_mx, s2_mx;
  logic [22:0] s1_io, s2_io;

  function automatic logic [31:0] p3_word(logic [5:0] mx, logic [22:0] io);
    logic [31:0] w;
    for (int b = 0; b < 32; b++) begin
      if (b >= 10 && b <= 14) w[b] = mx[b-10];
      else if (b == 24)       w[b] = mx[5];
      else if (b < 10)        w[b] = io[b];
      else if (b <= 23)       w[b] = io[b-5];
      else if (b <= 28)       w[b] = io[b-6];
      else                    w[b] = 1'b0;
    end
    return w;
  endfunction

  function automatic void model_reset();
    m_p0o = 0; m_p0d = 0; m_p1o = 0; m_p1d = 0; m_p2o = 0; m_p2d = 0;
    m_p3o = 0; m_sel = 0; m_rd = 0;
    s1_p0 = 0; s2_p0 = 0; s1_p1 = 0; s2_p1 = 0; s1_p2 = 0; s2_p2 = 0;
    s1_mx = 0; s2_mx = 0; s1_io = 0; s2_io = 0;
  endfunction

  function automatic void model_step();
    logic [31:0] r;
    if (!rst_n) begin model_reset(); return; end
    case (bus_addr)
      8'h00: r = p3_word(s2_mx, s2_io);
      8'h0C: r = m_p3o;
      8'h18: r = m_p2d;
      8'h1C: r = s2_p2;
      8'h30: r = m_sel;
      8'h40: r = s2_p0;
      8'h4C: r = m_p0o;
      8'h58: r = m_p0d;
      8'h60: r = s2_p1;
      8'h6C: r = m_p1o;
      8'h78: r = m_p1d;
      default: r = 0;
    endcase
    m_rd = r;
    if (bus_we) begin
      case (bus_addr)
        8'h04: m_p3o = m_p3o | (bus_wdata & 32'h7EFF_FFFF);
        8'h08: m_p3o = m_p3o & ~bus_wdata;
        8'h10: m_p2d = m_p2d | (bus_wdata & 32'h7E00_1FFF);
        8'h14: m_p2d = m_p2d & ~bus_wdata;
        8'h20: m_p2o = m_p2o | (bus_wdata & 32'h1FFF);
        8'h24: m_p2o = m_p2o & ~bus_wdata;
        8'h28: m_sel = m_sel | (bus_wdata & 32'h7);
        8'h2C: m_sel = m_sel & ~bus_wdata;
        8'h44: m_p0o = m_p0o | (bus_wdata & 32'hFF);
        8'h48: m_p0o = m_p0o & ~bus_wdata;
        8'h50: m_p0d = m_p0d | (bus_wdata & 32'hFF);
        8'h54: m_p0d = m_p0d & ~bus_wdata;
        8'h64: m_p1o = m_p1o | (bus_wdata & 32'hFF_FFFF);
        8'h68: m_p1o = m_p1o & ~bus_wdata;
        8'h70: m_p1d = m_p1d | (bus_wdata & 32'hFF_FFFF);
        8'h74: m_p1d = m_p1d & ~bus_wdata;
        default: ;
      endcase
    end
    s2_p0 = s1_p0; s1_p0 = 32'(p0_pin_in);
    s2_p1 = s1_p1; s1_p1 = 32'(p1_pin_in);
    s2_p2 = s1_p2; s1_p2 = 32'(p2_pin_in);
    s2_mx = s1_mx; s1_mx = mix_pin_in;
    s2_io = s1_io; s1_io = ino_pin_in;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: model advances with the inputs now applied, outputs compared after the edge
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_tag, "read data", bus_rdata, m_rd);
    chk("R2", "p0 out", 32'(p0_pin_out), m_p0o);
    chk("R4", "p0 oe", 32'(p0_pin_oe), m_p0d);
    chk("R3", "p1 out", 32'(p1_pin_out), m_p1o);
    chk("R4", "p1 oe", 32'(p1_pin_oe), m_p1d);
    chk("R6", "p2 out", 32'(p2_pin_out), m_p2o);
    chk("R6", "p2 oe", 32'(p2_pin_oe), m_p2d & 32'h1FFF);
    chk("R7", "p2 sel", 32'(p2_sel), m_sel);
    chk("R8", "mix out", 32'(mix_pin_out), (m_p3o >> 25) & 32'h3F);
    chk("R8", "mix oe", 32'(mix_pin_oe), (m_p2d >> 25) & 32'h3F);
    chk("R10", "out-only", 32'(outo_pin_out), m_p3o & 32'hFF_FFFF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cur_tag = tag; bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    cycle();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cur_tag = tag; bus_addr = a; bus_we = 1'b0;
    cycle();
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    chk("R1", "enables after reset", 32'({p0_pin_oe, p2_pin_oe, mix_pin_oe}), 0);
    chk("R1", "levels after reset", 32'({p0_pin_out, p2_pin_out, p2_sel, mix_pin_out}), 0);
    chk("R1", "read data after reset", bus_rdata, 0);

    // port 0
    wr(8'h44, 32'h0000_00A5, "R2"); rd(8'h4C, "R5");
    wr(8'h48, 32'h0000_0021, "R3"); rd(8'h4C, "R5");
    wr(8'h50, 32'h0000_000F, "R4"); rd(8'h58, "R4");
    wr(8'h54, 32'h0000_0003, "R3"); rd(8'h58, "R5");
    // port 1
    wr(8'h64, 32'hFFFF_FFFF, "R2"); wr(8'h68, 32'h00F0_0F0F, "R3"); rd(8'h6C, "R5");
    wr(8'h70, 32'h0081_8000, "R4"); rd(8'h78, "R5");
    // port 2 and select
    wr(8'h20, 32'hFFFF_FFFF, "R6"); wr(8'h24, 32'h0000_1555, "R6");
    wr(8'h10, 32'h0000_0F0F, "R6"); rd(8'h18, "R6");
    wr(8'h14, 32'h0000_0003, "R6"); rd(8'h18, "R6");
    wr(8'h28, 32'h0000_00FF, "R7"); rd(8'h30, "R7");
    wr(8'h2C, 32'h0000_0005, "R7"); rd(8'h30, "R7");
    // latch retained while input, driven once enabled
    wr(8'h54, 32'h0000_00FF, "R13"); wr(8'h44, 32'h0000_0080, "R13");
    wr(8'h50, 32'h0000_0080, "R13"); wr(8'h54, 32'h0000_0080, "R13");
    rd(8'h4C, "R13");
    // port 3 outputs
    wr(8'h04, 32'hFFFF_FFFF, "R8"); rd(8'h0C, "R14");
    wr(8'h08, 32'h5500_AAAA, "R10"); rd(8'h0C, "R10");
    wr(8'h10, 32'h7E00_0000, "R8"); rd(8'h18, "R8");
    wr(8'h14, 32'h2A00_0000, "R8");
    wr(8'h14, 32'hFFFF_FFFF, "R8");
    wr(8'h10, 32'h1400_1010, "R8");          // both ports' enables in one write
    rd(8'h18, "R8");
    // input-only walking one
    for (int k = 0; k < 23; k++) begin
      ino_pin_in = 23'(1) << k;
      repeat (3) rd(8'h00, "R11");
    end
    ino_pin_in = '0;
    for (int n = 0; n < 6; n++) begin
      mix_pin_in = 6'(1) << n;
      repeat (3) rd(8'h00, "R9");
    end
    mix_pin_in = 6'h2D; ino_pin_in = 23'h55_AA33;
    repeat (3) rd(8'h00, "R9");
    // plain-port inputs and latency
    p1_pin_in = 24'hC3_5A96; p2_pin_in = 13'h1ABC;
    repeat (3) rd(8'h60, "R12");
    repeat (3) rd(8'h1C, "R12");
    for (int i = 0; i < 10; i++) begin
      p0_pin_in = 8'(i * 37 + 5);
      rd(8'h40, "R12");
    end
    repeat (2) rd(8'h40, "R12");
    // unmapped and write-only reads, writes to read-only offsets
    rd(8'h34, "R14"); rd(8'h7C, "R14"); rd(8'h04, "R14"); rd(8'h44, "R14");
    wr(8'h00, 32'hFFFF_FFFF, "R14"); wr(8'h3C, 32'hFFFF_FFFF, "R14");
    wr(8'h4C, 32'hFFFF_FFFF, "R14"); wr(8'h58, 32'hFFFF_FFFF, "R14");
    wr(8'h18, 32'hFFFF_FFFF, "R14"); wr(8'h0C, 32'hFFFF_FFFF, "R14");
    rd(8'h0C, "R14"); rd(8'h58, "R14"); rd(8'h18, "R14");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule